// File: doc/BRIEF.md
# Fan tachometer pulse counter

This block measures fan speed. The fan's tachometer output is a slow square wave. The block counts how many reference ticks fall within one period of that wave, where a period runs from one rising edge to the next. Counting does not start from zero. It starts from a programmable start value, and software can use that offset to move the useful 8-bit range towards slow or fast fans. At every rising edge the running count is captured into a read-only result register, and the counter is then reloaded with the start value.

Writing the start value restarts the measurement at once. The captured results are therefore held as untrusted until enough complete periods have passed, and a valid flag shows when that point is reached. The raw fan input is asynchronous, so it is synchronised first. The counter saturates and does not wrap, so a stalled or very slow fan reads as the maximum count. Access goes through a one-bit register select, a write strobe, write data and combinational read data.

Top module: `fan_tach_meter`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), the result register reads 0x00, the start value reads 0x00 and meas_valid is 0.
- R2: tach_in passes through a two-flop synchroniser followed by a rising-edge detector. A low-to-high change of tach_in that is first sampled at clock edge c updates the result at edge c+2. A high-to-low change of tach_in has no effect on the result or on the running count.
- R3: The running count increases by one at each clock edge where tick_en is 1, and holds at each edge where tick_en is 0. This applies in cycles with no start-value write and no rising edge.
- R4: At a detected rising edge the result register takes the running count, and the counter reloads the start value in the same cycle. The result therefore equals the start value plus the ticks counted since the previous rising edge, and it holds until the next rising edge.
- R5: The running count saturates at 0xFF. Further ticks leave it at 0xFF. The next rising edge captures 0xFF and reloads the start value.
- R6: A write with reg_sel=1 stores reg_wdata as the start value and loads the running count with it at the same clock edge. A rising edge detected in that same cycle is ignored: the result is unchanged.
- R7: reg_rdata shows the result register when reg_sel=0 and the start value when reg_sel=1. A write with reg_sel=0 changes neither register.
- R8: meas_valid drops to 0 at the edge of any start-value write. It becomes 1 once three rising edges (two complete periods) have been detected since that write or since reset, and it stays 1 until the next write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Reference tick enable, one count per enabled cycle |
| tach_in | input | 1 | Raw asynchronous fan tachometer input |
| reg_sel | input | 1 | Register select: 0 selects the result, 1 selects the start value |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| meas_valid | output | 1 | Result trusted: two complete periods since the last restart |

## Verification
Pulse trains with a continuous tick give start value plus period minus one. This separates a correct reload from an off-by-one error in the capture timing. Trains with a one-in-four tick give start value plus period over four, which shows that tick_en is honoured. A very long period and a start value near the top both exercise saturation, which a wrapping counter would report as a small number. Single, hand-placed edges check the two-cycle synchroniser latency, show that falling edges are ignored, cover a start-value write that lands on a rising edge, and walk the valid flag through edges one, two and three.

// File: rtl/fan_tach_pkg.sv
`timescale 1ns/1ps
package fan_tach_pkg;
   // register select encodings
   localparam logic SEL_RESULT  = 1'b0;
   localparam logic SEL_PRELOAD = 1'b1;
endpackage

// File: rtl/fan_tach_sync.sv
`timescale 1ns/1ps
module fan_tach_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise
);
   logic [STAGES-1:0] sr;
   logic              prev;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sr   <= '0;
         prev <= 1'b0;
      end else begin
         sr   <= {sr[STAGES-2:0], async_in};
         prev <= sr[STAGES-1];
      end
   end

   assign rise = sr[STAGES-1] & ~prev;

   AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise); // R2
   AST_RISE_FROM_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rise) |-> $past(async_in, 2)); // R2
endmodule

// File: rtl/fan_tach_counter.sv
`timescale 1ns/1ps
module fan_tach_counter #(
   parameter int CNT_W    = 8,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             restart,
   input  logic [CNT_W-1:0] restart_val,
   input  logic             rise,
   input  logic [CNT_W-1:0] reload_val,
   output logic [CNT_W-1:0] cnt
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] cnt_inc;

   generate
      if (SATURATE) begin : g_sat
         assign cnt_inc = (cnt == CNT_MAX) ? cnt : cnt + CNT_W'(1);
         AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
            (!restart && !rise && tick_en && cnt == CNT_MAX) |=> cnt == CNT_MAX); // R5
      end else begin : g_wrap
         assign cnt_inc = cnt + CNT_W'(1);
      end
   endgenerate

   // priority: restart write, then edge reload, then tick
   always_ff @(posedge clk) begin
      if (!rst_n)          cnt <= '0;
      else if (restart)    cnt <= restart_val;
      else if (rise)       cnt <= reload_val;
      else if (tick_en)    cnt <= cnt_inc;
   end

   AST_RESTART_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> cnt == $past(restart_val)); // R6
   AST_EDGE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (rise && !restart) |=> cnt == $past(reload_val)); // R4
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!restart && !rise && !tick_en) |=> $stable(cnt)); // R3
endmodule

// File: rtl/fan_tach_regs.sv
`timescale 1ns/1ps
module fan_tach_regs
   import fan_tach_pkg::*;
#(
   parameter int CNT_W        = 8,
   parameter int VALID_PULSES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic             reg_sel,
   input  logic [CNT_W-1:0] reg_wdata,
   input  logic             rise,
   input  logic [CNT_W-1:0] cnt_in,
   output logic             pre_wr,
   output logic [CNT_W-1:0] preload,
   output logic [CNT_W-1:0] reg_rdata,
   output logic             meas_valid
);
   // a full period needs an opening edge, so one more edge than periods
   localparam int            EDGES_NEEDED = VALID_PULSES + 1;
   localparam int            EW           = $clog2(EDGES_NEEDED + 1);
   localparam logic [EW-1:0] NEED_V       = EW'(EDGES_NEEDED);

   logic [CNT_W-1:0] result;
   logic [EW-1:0]    edge_cnt;

   assign pre_wr = reg_wr && (reg_sel == SEL_PRELOAD);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         preload  <= '0;
         result   <= '0;
         edge_cnt <= '0;
      end else if (pre_wr) begin
         preload  <= reg_wdata;
         edge_cnt <= '0;
      end else if (rise) begin
         result <= cnt_in;
         if (edge_cnt != NEED_V) edge_cnt <= edge_cnt + EW'(1);
      end
   end

   assign meas_valid = (edge_cnt == NEED_V);
   assign reg_rdata  = (reg_sel == SEL_PRELOAD) ? preload : result;

   AST_RESULT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (rise && !pre_wr) |=> result == $past(cnt_in)); // R4
   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(rise && !pre_wr) |=> $stable(result)); // R4
   AST_PRELOAD_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      pre_wr |=> preload == $past(reg_wdata)); // R6
   AST_RESULT_READONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_sel == SEL_RESULT) |=> $stable(preload)); // R7
   AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      pre_wr |=> !meas_valid); // R8
   AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (meas_valid && !pre_wr) |=> meas_valid); // R8
endmodule

// File: rtl/fan_tach_meter.sv
`timescale 1ns/1ps
module fan_tach_meter #(
   parameter int CNT_W        = 8,
   parameter int SYNC_STAGES  = 2,
   parameter int VALID_PULSES = 2,
   parameter bit SATURATE     = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             tach_in,
   input  logic             reg_sel,
   input  logic             reg_wr,
   input  logic [CNT_W-1:0] reg_wdata,
   output logic [CNT_W-1:0] reg_rdata,
   output logic             meas_valid
);
   if (CNT_W < 2) begin : g_bad_width
      $error("fan_tach_meter: CNT_W must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("fan_tach_meter: SYNC_STAGES must be at least 2");
   end
   if (VALID_PULSES < 1) begin : g_bad_valid
      $error("fan_tach_meter: VALID_PULSES must be at least 1");
   end

   logic             rise;
   logic             pre_wr;
   logic [CNT_W-1:0] preload;
   logic [CNT_W-1:0] cnt;

   fan_tach_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (tach_in),
      .rise     (rise)
   );

   fan_tach_counter #(.CNT_W(CNT_W), .SATURATE(SATURATE)) u_cnt (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick_en     (tick_en),
      .restart     (pre_wr),
      .restart_val (reg_wdata),
      .rise        (rise),
      .reload_val  (preload),
      .cnt         (cnt)
   );

   fan_tach_regs #(.CNT_W(CNT_W), .VALID_PULSES(VALID_PULSES)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_wr     (reg_wr),
      .reg_sel    (reg_sel),
      .reg_wdata  (reg_wdata),
      .rise       (rise),
      .cnt_in     (cnt),
      .pre_wr     (pre_wr),
      .preload    (preload),
      .reg_rdata  (reg_rdata),
      .meas_valid (meas_valid)
   );
endmodule

// File: tb/fan_tach_meter_bench.sv
`timescale 1ns/1ps
module fan_tach_meter_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b0;
   logic       tach_in = 1'b0;
   logic       reg_sel = 1'b0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       meas_valid;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   fan_tach_meter u_fan_tach_meter (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .tach_in(tach_in),
      .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .meas_valid(meas_valid)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic rd(input logic sel, output int val);
      reg_sel = sel;
      #0.5;
      val = int'(reg_rdata);
      reg_sel = 1'b0;
   endtask

   task automatic wr(input logic sel, input logic [7:0] d);
      reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
      step();
      reg_wr = 1'b0; reg_sel = 1'b0;
   endtask

   // write the start value, then give k ticks
   task automatic arm(input logic [7:0] pre, input int k);
      wr(1'b1, pre);
      tick_en = 1'b1;
      repeat (k) step();
      tick_en = 1'b0;
   endtask

   // one isolated rising edge, then back low and settled
   task automatic fire(input string req, input int exp_res, input int exp_valid);
      int v;
      tach_in = 1'b1;
      repeat (3) step();
      tach_in = 1'b0;
      repeat (3) step();
      rd(1'b0, v);
      chk(req, "result after edge", v, exp_res);
      chk("R8", "valid after edge", int'(meas_valid), exp_valid);
   endtask

   task automatic t_reset();
      int v;
      rst_n = 1'b0;
      repeat (3) step();
      rst_n = 1'b1;
      step();
      rd(1'b0, v); chk("R1", "result after reset", v, 0);
      rd(1'b1, v); chk("R1", "start value after reset", v, 0);
      chk("R1", "valid after reset", int'(meas_valid), 0);
   endtask

   task automatic t_latency();
      int v;
      arm(8'h10, 5);
      rd(1'b1, v); chk("R7", "start value readback", v, 'h10);
      tach_in = 1'b1;
      step(); rd(1'b0, v); chk("R2", "result one edge after input", v, 0);
      step(); rd(1'b0, v); chk("R2", "result two edges after input", v, 0);
      step(); rd(1'b0, v); chk("R2", "result three edges after input", v, 'h15);
      tach_in = 1'b0;
      repeat (3) step();
      wr(1'b0, 8'hAA);
      rd(1'b0, v); chk("R7", "result after write to sel 0", v, 'h15);
      rd(1'b1, v); chk("R7", "start value after write to sel 0", v, 'h10);
   endtask

   task automatic t_fall();
      int v;
      tach_in = 1'b1;
      repeat (3) step();
      rd(1'b0, v); chk("R4", "reload value captured", v, 'h10);
      tick_en = 1'b1; repeat (7) step(); tick_en = 1'b0;
      tach_in = 1'b0;
      repeat (5) step();
      rd(1'b0, v); chk("R2", "result after falling edge", v, 'h10);
      fire("R2", 'h17, 1);
   endtask

   task automatic t_valid();
      chk("R8", "valid before write", int'(meas_valid), 1);
      arm(8'h30, 0);
      chk("R8", "valid right after write", int'(meas_valid), 0);
      fire("R8", 'h30, 0);
      fire("R8", 'h30, 0);
      fire("R8", 'h30, 1);
   endtask

   task automatic t_collide();
      int v;
      tach_in = 1'b1;
      step(); step();
      wr(1'b1, 8'h50);
      rd(1'b0, v); chk("R6", "edge ignored during write", v, 'h30);
      chk("R8", "valid after colliding write", int'(meas_valid), 0);
      tach_in = 1'b0;
      repeat (3) step();
      tick_en = 1'b1; repeat (4) step(); tick_en = 1'b0;
      fire("R6", 'h54, 0);
   endtask

   task automatic t_restart();
      arm(8'h00, 50);
      arm(8'h20, 9);
      fire("R6", 'h29, 0);
   endtask

   // n pulses of period p, tick every d cycles (d=1: every cycle)
   task automatic train(input string req, input logic [7:0] pre, input int p, input int d,
                        input int n, input int exp_res);
      int v;
      arm(pre, 0);
      for (int c = 0; c < n * p; c++) begin
         tach_in = ((c % p) < (p / 2));
         tick_en = (d == 1) ? 1'b1 : ((c % d) == 1);
         step();
      end
      tach_in = 1'b0; tick_en = 1'b0;
      repeat (4) step();
      rd(1'b0, v);
      chk(req, "pulse train result", v, exp_res);
      chk("R8", "valid after pulse train", int'(meas_valid), 1);
   endtask

   task automatic t_sat();
      train("R5", 8'hF0, 40, 1, 4, 'hFF);
      arm(8'h00, 300);
      fire("R5", 'hFF, 0);
      fire("R5", 'h00, 0);
   endtask

   initial begin
      step();
      t_reset();
      t_latency();
      t_fall();
      t_valid();
      t_collide();
      t_restart();
      train("R4", 8'h05, 24, 1, 4, 'h05 + 23);
      train("R3", 8'h40, 32, 4, 4, 'h40 + 8);
      t_sat();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule